// File: doc/BRIEF.md
# Soft-Stepping Microphone Gain Controller

This block holds the gain applied by a microphone programmable-gain stage, in half-decibel codes. It moves that gain one code per sample toward a requested target. The request comes from a fixed gain field or from an external automatic-gain loop, chosen by a select input. A two-bit input-resistance code then shifts the request by +6 dB, 0 dB or −6 dB, and the result is clamped to the legal code range.

On every sample strobe, the block also scales the signed input sample by the gain currently applied and registers the saturated result. A mute input freezes that output sample. A settled flag reports whether the applied gain has reached the target. Dropping the stage enable returns the gain to 0 dB on the next clock.

Top module: `pga_gain_stepper`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, gain_code is 0 and sample_out is 0.
- R2: When auto_en is 1 the requested code is agc_gain; when it is 0 it is fixed_gain. Both are 7-bit codes of 0.5 dB each.
- R3: The offset from res_sel is as follows: 2'b01 adds 12 codes (+6 dB), 2'b11 subtracts 12 codes (−6 dB), and 2'b10 and 2'b00 add nothing.
- R4: The offset target is clamped to the range 0 to 127.
- R5: Each sample_strobe taken with pga_en high moves gain_code exactly one code toward the target, and leaves it unchanged once it is equal. Without a strobe, gain_code does not change.
- R6: While pga_en is low the target is 0, and gain_code becomes 0 at the next clock edge, with no stepping.
- R7: gain_settled is 1 exactly when gain_code equals the current target.
- R8: A strobe with mute low loads sample_out with the input sample scaled by the gain in force before that strobe's step. For a gain code g, the sample is multiplied by M(g mod 12) = round(256·2^((g mod 12)/12)), shifted left by g/12 (integer division), then arithmetically shifted right by 8, and saturated to the signed data width.
- R9: A strobe taken with mute high leaves sample_out unchanged, so the output holds until a strobe arrives with mute low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_strobe | input | 1 | One-cycle pulse per audio sample |
| pga_en | input | 1 | Gain stage enable; low forces 0 dB |
| auto_en | input | 1 | Selects agc_gain instead of fixed_gain |
| fixed_gain | input | GW | Fixed gain request, 0.5 dB per code |
| agc_gain | input | GW | Gain request from the automatic loop |
| res_sel | input | 2 | Input-resistance code selecting the ±6 dB offset |
| mute | input | 1 | Freezes sample_out while high |
| sample_in | input | DW | Signed input sample |
| gain_code | output | GW | Gain currently applied |
| gain_settled | output | 1 | High when gain_code equals the target |
| sample_out | output | DW | Signed scaled sample, or the held sample |

## Verification
The properties assume a run that starts in reset, and inputs that are steady around each rising edge. They place no limit on how often configuration changes or strobes arrive. The stimulus changes configuration and data only on falling edges, and always with the strobe low. Each strobe is a single-cycle pulse, so every stepping property sees a clean edge. The sequences step the gain up and down, saturate it at both clamps, and flip the source, offset, mute and enable in the middle of the run.

// File: rtl/pga_gain_stepper.sv
module pga_gain_stepper #(
  parameter int GW = 7,
  parameter int DW = 16,
  parameter int OFFSET_CODES = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_strobe,
  input  logic                 pga_en,
  input  logic                 auto_en,
  input  logic [GW-1:0]        fixed_gain,
  input  logic [GW-1:0]        agc_gain,
  input  logic [1:0]           res_sel,
  input  logic                 mute,
  input  logic signed [DW-1:0] sample_in,
  output logic [GW-1:0]        gain_code,
  output logic                 gain_settled,
  output logic signed [DW-1:0] sample_out
);
  localparam int MAXCODE = (1 << GW) - 1;
  localparam int MAXSH   = MAXCODE / 12;
  localparam int SHW     = $clog2(MAXSH + 1) + 1;
  localparam int PW      = DW + 11 + MAXSH;
  localparam int SW      = GW + 2;

  logic [GW-1:0]        request;
  logic signed [SW-1:0] offset, shifted;
  logic [GW-1:0]        target;

  assign request = auto_en ? agc_gain : fixed_gain;

  always_comb begin
    case (res_sel)
      2'b01:   offset = SW'(OFFSET_CODES);
      2'b11:   offset = -SW'(OFFSET_CODES);
      default: offset = '0;
    endcase
  end

  assign shifted = $signed({2'b00, request}) + offset;

  always_comb begin
    if (!pga_en)                            target = '0;
    else if (shifted < 0)                   target = '0;
    else if (shifted > SW'(MAXCODE))        target = GW'(MAXCODE);
    else                                    target = shifted[GW-1:0];
  end

  assign gain_settled = (gain_code == target);

  always_ff @(posedge clk) begin
    if (!rst_n)                  gain_code <= '0;
    else if (!pga_en)            gain_code <= '0;
    else if (sample_strobe) begin
      if (gain_code < target)      gain_code <= gain_code + 1'b1;
      else if (gain_code > target) gain_code <= gain_code - 1'b1;
    end
  end

  logic [3:0]           frac;
  logic [SHW-1:0]       whole;
  logic [9:0]           mant;
  logic signed [PW-1:0] prod, scaled;
  logic signed [DW-1:0] sat;

  assign frac  = 4'(gain_code % 12);
  assign whole = SHW'(gain_code / 12);

  always_comb begin
    case (frac)
      4'd0:    mant = 10'd256;
      4'd1:    mant = 10'd271;
      4'd2:    mant = 10'd287;
      4'd3:    mant = 10'd304;
      4'd4:    mant = 10'd323;
      4'd5:    mant = 10'd342;
      4'd6:    mant = 10'd362;
      4'd7:    mant = 10'd384;
      4'd8:    mant = 10'd406;
      4'd9:    mant = 10'd431;
      4'd10:   mant = 10'd456;
      default: mant = 10'd483;
    endcase
  end

  assign prod   = PW'(sample_in) * $signed(PW'({1'b0, mant}));
  assign scaled = (prod <<< whole) >>> 8;

  always_comb begin
    if (scaled > PW'((1 << (DW - 1)) - 1))   sat = {1'b0, {(DW-1){1'b1}}};
    else if (scaled < -PW'(1 << (DW - 1)))   sat = {1'b1, {(DW-1){1'b0}}};
    else                                     sat = scaled[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       sample_out <= '0;
    else if (sample_strobe && !mute)  sample_out <= sat;
  end
endmodule

module pga_gain_stepper_chk #(
  parameter int GW = 7,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_strobe,
  input logic          pga_en,
  input logic          mute,
  input logic [GW-1:0] gain_code,
  input logic          gain_settled,
  input logic [DW-1:0] sample_out
);
  a_r5_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_strobe && pga_en) |=> $stable(gain_code));
  a_r5_settled_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && pga_en && gain_settled) |=> $stable(gain_code));
  a_r5_moves_when_off_target: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && pga_en && !gain_settled) |=> (gain_code != $past(gain_code)));
  a_r6_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pga_en |=> (gain_code == '0));
  a_r9_mute_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_strobe && mute) |=> $stable(sample_out));
endmodule

bind pga_gain_stepper pga_gain_stepper_chk #(.GW(GW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_strobe(sample_strobe), .pga_en(pga_en),
  .mute(mute), .gain_code(gain_code), .gain_settled(gain_settled),
  .sample_out(sample_out)
);

// File: tb/pga_gain_stepper_test.sv
module pga_gain_stepper_test;
  logic clk = 0, rst_n = 0, sample_strobe = 0, pga_en = 1, auto_en = 0, mute = 0;
  logic [6:0] fixed_gain = 0, agc_gain = 0;
  logic [1:0] res_sel = 2'b10;
  logic signed [15:0] sample_in = 0;
  logic [6:0] gain_code;
  logic gain_settled;
  logic signed [15:0] sample_out;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pga_gain_stepper uut (.*);

  typedef struct {int gain; bit settled; int dout; string tag;} exp_t;
  exp_t q[$];
  int mgain = 0, mdout = 0;

  function automatic int tgt();
    int t;
    if (!pga_en) return 0;
    t = auto_en ? int'(agc_gain) : int'(fixed_gain);
    if (res_sel == 2'b01) t += 12;
    else if (res_sel == 2'b11) t -= 12;
    if (t < 0) t = 0;
    if (t > 127) t = 127;
    return t;
  endfunction

  function automatic int model_out(int d, int g);
    longint p;
    int m;
    m = $rtoi(256.0 * (2.0 ** ((g % 12) / 12.0)) + 0.5);
    p = longint'(d) * m;
    p = p <<< (g / 12);
    p = p >>> 8;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int d, input string tag);
    exp_t e;
    @(negedge clk);
    sample_in = 16'(d);
    sample_strobe = 1;
    if (!mute) mdout = model_out(d, mgain);
    if (!pga_en) mgain = 0;
    else if (mgain < tgt()) mgain++;
    else if (mgain > tgt()) mgain--;
    e.gain = mgain; e.settled = (mgain == tgt()); e.dout = mdout; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    sample_strobe = 0;
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (sample_strobe) begin
        @(negedge clk);
        e = q.pop_front();
        check({e.tag, " gain"}, int'(gain_code), e.gain);
        check({e.tag, " R7 settled"}, int'(gain_settled), int'(e.settled));
        check({e.tag, " dout"}, int'(sample_out), e.dout);
      end
    end
  end

  initial begin : watchdog
    #(20ns * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 gain in reset", int'(gain_code), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 gain after reset", int'(gain_code), 0);
    check("R1 dout after reset", int'(sample_out), 0);
    check("R7 settled at zero", int'(gain_settled), 1);

    fixed_gain = 5;
    for (int i = 0; i < 6; i++) pulse(1000, "R2 R5 R8 fixed up");
    repeat (5) @(negedge clk);
    check("R5 no strobe hold", int'(gain_code), 5);

    res_sel = 2'b01;
    @(negedge clk);
    check("R7 unsettled after offset", int'(gain_settled), 0);
    for (int i = 0; i < 14; i++) pulse(-700, "R3 plus offset");
    check("R3 plus offset value", int'(gain_code), 17);

    res_sel = 2'b11;
    for (int i = 0; i < 18; i++) pulse(1234, "R3 R4 minus clamp low");
    check("R4 clamp low", int'(gain_code), 0);

    res_sel = 2'b00; fixed_gain = 24;
    for (int i = 0; i < 26; i++) pulse(-3000, "R3 R8 code 00");
    check("R3 code 00 no offset", int'(gain_code), 24);

    auto_en = 1; agc_gain = 36;
    for (int i = 0; i < 14; i++) pulse(5000, "R2 auto source");
    check("R2 auto value", int'(gain_code), 36);

    auto_en = 0; fixed_gain = 120; res_sel = 2'b01;
    for (int i = 0; i < 95; i++) pulse(100 + i, "R4 R8 clamp high");
    check("R4 clamp high", int'(gain_code), 127);
    pulse(-20000, "R8 negative saturation");

    mute = 1;
    pulse(7, "R9 mute first");
    pulse(-9, "R9 mute second");
    mute = 0;
    pulse(3, "R9 unmute");

    pga_en = 0;
    @(negedge clk);
    check("R6 zero next edge", int'(gain_code), 0);
    mgain = 0;
    pulse(4321, "R6 disabled unity");
    check("R6 disabled dout", int'(sample_out), 4321);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule